// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides whether a conditional-store or exclusive memory access may go ahead. The translation logic supplies a fault code, the page's read and write permissions and the page's cache-attribute class. A 6-bit atomic-control value holds a 2-bit policy field for each cacheable class. A flag says whether a data cache is present. From these inputs the checker produces a single exception strobe and a cause code. Address translation and the memory access itself happen elsewhere.

The checker applies its rules in a fixed order. A translation fault wins over everything else. For a conditional store, the permission test comes next. The attribute-driven policy check comes last. The verdict is registered, so it appears in the cycle after the request strobe. Three parameters set the numeric values of the checker's own causes, and a translation fault code passes through to the output unchanged.

Top module: `atomic_access_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `exc_valid` is 0 and `exc_cause` is 0.
- R2: The verdict for a request sampled with `req_valid`=1 at a clock edge is visible in the following cycle. Any cycle whose previous edge saw `req_valid`=0 shows `exc_valid`=0 and `exc_cause`=0. Whenever `exc_valid` is 0, `exc_cause` is 0.
- R3: A nonzero `xlt_fault` raises an exception with `exc_cause` equal to that fault value, whatever the other inputs are.
- R4: A conditional store (`req_excl`=0) with no fault, on a page that lacks read permission or lacks write permission, raises cause `CODE_STORE_DENY` (default 29).
- R5: An exclusive access (`req_excl`=1) ignores `pg_rd` and `pg_wr`.
- R6: When `has_dcache`=0, the page attribute is replaced by bypass (code 0). The policy field `atom_ctl[1:0]` then decides, even for an isolate page.
- R7: Attribute code 0 (bypass) selects `atom_ctl[1:0]`, code 1 (write-through) selects `atom_ctl[3:2]` and code 2 (write-back) selects `atom_ctl[5:4]`. A nonzero selected field raises no exception.
- R8: A zero selected field raises `CODE_LDST_ERR` (default 3) for a conditional store and `CODE_EXCL_ERR` (default 37) for an exclusive access.
- R9: Attribute code 3 (isolate) with a data cache present raises `CODE_LDST_ERR` for both access kinds, provided no earlier rule fired.
- R10: Attribute codes 4 to 7 with a data cache present raise no exception from the policy check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the other inputs are sampled with it |
| req_excl | input | 1 | 1 = exclusive access, 0 = conditional store |
| xlt_fault | input | FAULT_W (6) | Translation fault code, 0 = none |
| pg_rd | input | 1 | Page grants read |
| pg_wr | input | 1 | Page grants write |
| pg_attr | input | 3 | Cache class: 0 bypass, 1 write-through, 2 write-back, 3 isolate, 4-7 other |
| atom_ctl | input | FIELD_W*3 (6) | Per-class 2-bit policy fields |
| has_dcache | input | 1 | A data cache is configured |
| exc_valid | output | 1 | Exception verdict, one cycle after the request |
| exc_cause | output | FAULT_W (6) | Cause code when `exc_valid`=1, else 0 |

## Verification
The bound checker enforces several properties on every cycle: the quiet output when no request came before, fault pass-through and its priority, the store-deny verdict for a conditional store without full permission, the isolate verdict, and that an exclusive access never receives the store-deny cause. Some behaviour can only be shown by the bench's directed and random scenarios, which it compares against its own reference function. These are the mapping of each attribute code to its control bit pair, the substitution of bypass when no cache is present, the split of the zero-field cause by access kind, and the silence of attribute codes 4 to 7.

// File: rtl/aac_pkg.sv
package aac_pkg;
   localparam int ATTR_W = 3;

   typedef enum logic [ATTR_W-1:0] {
      ATTR_BYPASS  = 3'd0,
      ATTR_WTHRU   = 3'd1,
      ATTR_WBACK   = 3'd2,
      ATTR_ISOLATE = 3'd3
   } attr_e;

   // number of attribute classes that own a policy field (codes 0..N-1)
   localparam int POLICED_CLASSES = 3;
endpackage

// File: rtl/aac_perm_gate.sv
module aac_perm_gate (
   input  logic is_excl,
   input  logic rd_ok,
   input  logic wr_ok,
   output logic perm_bad
);
   // conditional stores need both rights; exclusive accesses are not gated here
   always_comb begin
      perm_bad = 1'b0;
      if (!is_excl) begin
         perm_bad = !(rd_ok && wr_ok);
      end
   end
endmodule

// File: rtl/aac_policy_sel.sv
module aac_policy_sel
   import aac_pkg::*;
#(
   parameter int FIELD_W = 2,
   parameter int NUM_CLS = POLICED_CLASSES,
   localparam int CTL_W  = FIELD_W * NUM_CLS
) (
   input  logic [ATTR_W-1:0] attr_in,
   input  logic              cache_on,
   input  logic [CTL_W-1:0]  ctl,
   output logic              isolate,
   output logic              field_zero
);
   logic [ATTR_W-1:0]  eff_attr;
   logic [NUM_CLS-1:0] zf;

   assign eff_attr = cache_on ? attr_in : ATTR_BYPASS;

   for (genvar g = 0; g < NUM_CLS; g++) begin : g_field
      assign zf[g] = (ctl[g*FIELD_W +: FIELD_W] == '0);
   end

   always_comb begin
      field_zero = 1'b0;
      for (int i = 0; i < NUM_CLS; i++) begin
         if (eff_attr == i[ATTR_W-1:0]) begin
            field_zero = zf[i];
         end
      end
   end

   assign isolate = (eff_attr == ATTR_ISOLATE);
endmodule

// File: rtl/aac_cause_enc.sv
module aac_cause_enc #(
   parameter int                FAULT_W         = 6,
   parameter logic [FAULT_W-1:0] CODE_STORE_DENY = 6'd29,
   parameter logic [FAULT_W-1:0] CODE_LDST_ERR   = 6'd3,
   parameter logic [FAULT_W-1:0] CODE_EXCL_ERR   = 6'd37
) (
   input  logic [FAULT_W-1:0] fault,
   input  logic               perm_bad,
   input  logic               is_excl,
   input  logic               isolate,
   input  logic               field_zero,
   output logic               exc,
   output logic [FAULT_W-1:0] cause
);
   // fixed priority: translation fault, permission, isolate, zero policy field
   always_comb begin
      exc   = 1'b1;
      cause = '0;
      if (fault != '0) begin
         cause = fault;
      end else if (perm_bad) begin
         cause = CODE_STORE_DENY;
      end else if (isolate) begin
         cause = CODE_LDST_ERR;
      end else if (field_zero) begin
         cause = is_excl ? CODE_EXCL_ERR : CODE_LDST_ERR;
      end else begin
         exc = 1'b0;
      end
   end
endmodule

// File: rtl/atomic_access_checker.sv
module atomic_access_checker
   import aac_pkg::*;
#(
   parameter int                 FAULT_W         = 6,
   parameter int                 FIELD_W         = 2,
   parameter logic [FAULT_W-1:0] CODE_STORE_DENY = 6'd29,
   parameter logic [FAULT_W-1:0] CODE_LDST_ERR   = 6'd3,
   parameter logic [FAULT_W-1:0] CODE_EXCL_ERR   = 6'd37,
   localparam int                CTL_W           = FIELD_W * POLICED_CLASSES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_excl,
   input  logic [FAULT_W-1:0] xlt_fault,
   input  logic               pg_rd,
   input  logic               pg_wr,
   input  logic [ATTR_W-1:0]  pg_attr,
   input  logic [CTL_W-1:0]   atom_ctl,
   input  logic               has_dcache,
   output logic               exc_valid,
   output logic [FAULT_W-1:0] exc_cause
);
   // elaboration-time parameter checks
   if (FAULT_W < 2 || FAULT_W > 16) begin : g_bad_fault_w
      $error("FAULT_W out of range");
   end
   if (FIELD_W < 1) begin : g_bad_field_w
      $error("FIELD_W must be at least 1");
   end
   if (CODE_STORE_DENY == '0 || CODE_LDST_ERR == '0 || CODE_EXCL_ERR == '0) begin : g_zero_code
      $error("cause codes must be nonzero");
   end
   if (CODE_STORE_DENY == CODE_LDST_ERR || CODE_STORE_DENY == CODE_EXCL_ERR ||
       CODE_LDST_ERR == CODE_EXCL_ERR) begin : g_dup_code
      $error("cause codes must be distinct");
   end

   logic               perm_bad;
   logic               isolate;
   logic               field_zero;
   logic               exc_d;
   logic [FAULT_W-1:0] cause_d;

   aac_perm_gate u_perm (
      .is_excl  (req_excl),
      .rd_ok    (pg_rd),
      .wr_ok    (pg_wr),
      .perm_bad (perm_bad)
   );

   aac_policy_sel #(
      .FIELD_W (FIELD_W),
      .NUM_CLS (POLICED_CLASSES)
   ) u_sel (
      .attr_in    (pg_attr),
      .cache_on   (has_dcache),
      .ctl        (atom_ctl),
      .isolate    (isolate),
      .field_zero (field_zero)
   );

   aac_cause_enc #(
      .FAULT_W         (FAULT_W),
      .CODE_STORE_DENY (CODE_STORE_DENY),
      .CODE_LDST_ERR   (CODE_LDST_ERR),
      .CODE_EXCL_ERR   (CODE_EXCL_ERR)
   ) u_enc (
      .fault      (xlt_fault),
      .perm_bad   (perm_bad),
      .is_excl    (req_excl),
      .isolate    (isolate),
      .field_zero (field_zero),
      .exc        (exc_d),
      .cause      (cause_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_valid <= 1'b0;
         exc_cause <= '0;
      end else if (req_valid && exc_d) begin
         exc_valid <= 1'b1;
         exc_cause <= cause_d;
      end else begin
         exc_valid <= 1'b0;
         exc_cause <= '0;
      end
   end
endmodule

// File: rtl/atomic_access_checker_sva.sv
module atomic_access_checker_sva
   import aac_pkg::*;
#(
   parameter int                 FAULT_W         = 6,
   parameter int                 FIELD_W         = 2,
   parameter logic [FAULT_W-1:0] CODE_STORE_DENY = 6'd29,
   parameter logic [FAULT_W-1:0] CODE_LDST_ERR   = 6'd3,
   localparam int                CTL_W           = FIELD_W * POLICED_CLASSES
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_excl,
   input logic [FAULT_W-1:0] xlt_fault,
   input logic               pg_rd,
   input logic               pg_wr,
   input logic [ATTR_W-1:0]  pg_attr,
   input logic [CTL_W-1:0]   atom_ctl,
   input logic               has_dcache,
   input logic               exc_valid,
   input logic [FAULT_W-1:0] exc_cause
);
   logic ctl_seen;
   assign ctl_seen = ^atom_ctl;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> (!exc_valid && exc_cause == '0)); // R2

   AST_CAUSE_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_cause == '0) || ctl_seen != ctl_seen); // R2

   AST_FAULT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && xlt_fault != '0) |-> (exc_valid && exc_cause == $past(xlt_fault))); // R3

   AST_STORE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && xlt_fault == '0 && !req_excl && !(pg_rd && pg_wr))
      |-> (exc_valid && exc_cause == CODE_STORE_DENY)); // R4

   AST_EXCL_NO_STORE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_excl && xlt_fault == '0) |-> (exc_cause != CODE_STORE_DENY)); // R5

   AST_ISOLATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && xlt_fault == '0 && has_dcache && pg_attr == ATTR_ISOLATE &&
            (req_excl || (pg_rd && pg_wr)))
      |-> (exc_valid && exc_cause == CODE_LDST_ERR)); // R9
endmodule

bind atomic_access_checker atomic_access_checker_sva #(
   .FAULT_W         (FAULT_W),
   .FIELD_W         (FIELD_W),
   .CODE_STORE_DENY (CODE_STORE_DENY),
   .CODE_LDST_ERR   (CODE_LDST_ERR)
) u_sva (.*);

// File: tb/test_atomic_access_checker.sv
module test_atomic_access_checker;
   localparam int FW = 6;
   localparam logic [FW-1:0] C_STORE = 6'd29;
   localparam logic [FW-1:0] C_LDST  = 6'd3;
   localparam logic [FW-1:0] C_EXCL  = 6'd37;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_excl = 1'b0;
   logic [FW-1:0] xlt_fault = '0;
   logic          pg_rd = 1'b0;
   logic          pg_wr = 1'b0;
   logic [2:0]    pg_attr = '0;
   logic [5:0]    atom_ctl = '0;
   logic          has_dcache = 1'b0;
   logic          exc_valid;
   logic [FW-1:0] exc_cause;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   atomic_access_checker i_atomic_access_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_excl(req_excl),
      .xlt_fault(xlt_fault), .pg_rd(pg_rd), .pg_wr(pg_wr), .pg_attr(pg_attr),
      .atom_ctl(atom_ctl), .has_dcache(has_dcache),
      .exc_valid(exc_valid), .exc_cause(exc_cause)
   );

   // reference model; returns {exc, cause} and names the deciding rule
   function automatic logic [FW:0] ref_model(input logic ex, input logic [FW-1:0] f,
                                              input logic r, input logic w, input logic [2:0] a,
                                              input logic [5:0] c, input logic dc,
                                              output string rule);
      logic [2:0] ea;
      logic [1:0] fld;
      ea = dc ? a : 3'd0;
      if (f != '0) begin rule = "R3"; return {1'b1, f}; end
      if (!ex && !(r && w)) begin rule = "R4"; return {1'b1, C_STORE}; end
      if (ea == 3'd3) begin rule = "R9"; return {1'b1, C_LDST}; end
      if (ea > 3'd3) begin rule = "R10"; return '0; end
      fld = c[2*ea +: 2];
      rule = dc ? "R7/R8" : "R6/R8";
      if (fld == 2'b00) return {1'b1, ex ? C_EXCL : C_LDST};
      return '0;
   endfunction

   task automatic check(input string req, input logic ev, input logic [FW-1:0] ec);
      checks++;
      if (exc_valid !== ev || exc_cause !== ec) begin
         fails++;
         $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
                  req, exc_valid, exc_cause, ev, ec);
      end
   endtask

   task automatic run(input logic ex, input logic [FW-1:0] f, input logic r, input logic w,
                      input logic [2:0] a, input logic [5:0] c, input logic dc,
                      input string tag);
      string rule;
      logic [FW:0] exp;
      exp = ref_model(ex, f, r, w, a, c, dc, rule);
      @(negedge clk);
      req_valid = 1'b1; req_excl = ex; xlt_fault = f; pg_rd = r; pg_wr = w;
      pg_attr = a; atom_ctl = c; has_dcache = dc;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " ", rule}, exp[FW], exp[FW-1:0]);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 during reset", 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, '0);

      // R3 fault priority over every later rule
      run(1'b0, 6'd12, 1'b0, 1'b0, 3'd3, 6'h00, 1'b1, "R3");
      run(1'b1, 6'd29, 1'b1, 1'b1, 3'd0, 6'h00, 1'b0, "R3");
      // R4 conditional store permission
      run(1'b0, '0, 1'b1, 1'b0, 3'd0, 6'h3f, 1'b1, "R4");
      run(1'b0, '0, 1'b0, 1'b1, 3'd2, 6'h3f, 1'b1, "R4");
      // R5 exclusive ignores permissions
      run(1'b1, '0, 1'b0, 1'b0, 3'd0, 6'h3f, 1'b1, "R5");
      // R6 no cache: bypass field decides even for isolate
      run(1'b0, '0, 1'b1, 1'b1, 3'd3, 6'h01, 1'b0, "R6");
      run(1'b1, '0, 1'b1, 1'b1, 3'd2, 6'h3c, 1'b0, "R6");
      // R7 field selection per class, only selected field zero
      run(1'b0, '0, 1'b1, 1'b1, 3'd1, 6'h33, 1'b1, "R7");
      run(1'b0, '0, 1'b1, 1'b1, 3'd1, 6'h3c, 1'b1, "R7");
      run(1'b1, '0, 1'b1, 1'b1, 3'd2, 6'h0f, 1'b1, "R7");
      run(1'b1, '0, 1'b1, 1'b1, 3'd2, 6'h30, 1'b1, "R7");
      // R8 zero field cause by access kind
      run(1'b0, '0, 1'b1, 1'b1, 3'd0, 6'h3c, 1'b1, "R8");
      run(1'b1, '0, 1'b1, 1'b1, 3'd0, 6'h3c, 1'b1, "R8");
      // R9 isolate with cache
      run(1'b1, '0, 1'b0, 1'b0, 3'd3, 6'h3f, 1'b1, "R9");
      run(1'b0, '0, 1'b1, 1'b1, 3'd3, 6'h3f, 1'b1, "R9");
      // R10 other classes silent even with zero fields
      run(1'b0, '0, 1'b1, 1'b1, 3'd5, 6'h00, 1'b1, "R10");
      run(1'b1, '0, 1'b0, 1'b0, 3'd7, 6'h00, 1'b1, "R10");
      // R2 idle cycle after a raised exception
      run(1'b0, 6'd9, 1'b0, 1'b0, 3'd0, 6'h00, 1'b1, "R2");
      @(negedge clk);
      check("R2 idle", 1'b0, '0);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [FW-1:0] f;
         f = ($urandom % 4 == 0) ? FW'($urandom % 63 + 1) : '0;
         run(1'($urandom), f, 1'($urandom), 1'($urandom), 3'($urandom % 8),
             6'($urandom), 1'($urandom % 4 != 0), "R2 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule